// File: doc/BRIEF.md
# Successive-Approximation Frequency Word Tracker

This block produces the frequency word that drives a phase-accumulator oscillator inside a closed measurement loop. An external comparator judges whether the synthesized tone is slower or faster than an unknown input. It reports that judgement as a direction bit, and a strobe marks each decision. A measurement opens with a binary search over the word range, one bit of resolution per approximation. It then settles into unit-step tracking, where the word dithers around the true value in a triangular pattern.

During tracking the block captures the word at every change of direction. A turn from falling to rising gives the lower extreme, and a turn from rising to falling gives the upper extreme. The midpoint of the two is offered as the reading. Tracking continues with no further command, so repeated readings follow a drifting input without a fresh search. A new start pulse begins a new search at any time.

Top module: `freq_word_tracker`

## Requirements
- R1: After reset the word is 0, the phase output is 0 (idle), both extremes are 0 and the valid flag is low.
- R2: On the clock after `start` is sampled high, the word is 2^(WORD_W-1) and the phase is 1 (search). `start` takes priority over a strobe in the same cycle.
- R3: In search, each approximation adds the current step to the word when `dir_up` is 1 and subtracts it when `dir_up` is 0. The first step is 2^(WORD_W-2) and each later step is half the previous one. In search the word is never 0.
- R4: An approximation uses only the strobe that completes a group of `dwell` strobes, and only that strobe's direction. A `dwell` of 0 acts as 1. The earlier strobes of a group leave the word unchanged.
- R5: The approximation made with step 1 moves the phase to 2 (track) on the same clock as it updates the word. Only `start` leaves track.
- R6: In track, each strobe changes the word by +1 when `dir_up` is 1 and by -1 when `dir_up` is 0.
- R7: In track the word saturates at 0 and at 2^WORD_W-1 and never wraps.
- R8: In track, a strobe with `dir_up`=1 after a track strobe with `dir_up`=0 loads the lower extreme with the word held before that strobe. A strobe with `dir_up`=0 after one with `dir_up`=1 loads the upper extreme in the same way.
- R9: The reading is floor((lower + upper) / 2). The valid flag rises once both extremes have been loaded since the last start.
- R10: A start during track restarts the search and clears the valid flag on the next clock.
- R11: With neither strobe nor start, the word and phase hold. Strobes in the idle phase are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new measurement |
| strobe | input | 1 | Comparator decision is present this cycle |
| dir_up | input | 1 | Decision: 1 raise the word, 0 lower it |
| dwell | input | DWELL_W | Strobes per search approximation (0 acts as 1) |
| fsw | output | WORD_W | Frequency word for the oscillator |
| phase | output | 2 | 0 idle, 1 search, 2 track |
| ext_lo | output | WORD_W | Lower extreme of the dither |
| ext_hi | output | WORD_W | Upper extreme of the dither |
| reading | output | WORD_W | Midpoint of the two extremes |
| reading_valid | output | 1 | Both extremes loaded since start |

## Verification
Every result is registered once. The word, phase, extremes, reading and valid flag all reflect a strobe or start on the first rising edge that samples it, with no further delay. The bench changes inputs at a falling edge, holds them across exactly one rising edge, and compares outputs at the next falling edge. A reference model in the bench steps in lockstep through the same search arithmetic and the same turn detection. Strobes that should have no effect, such as the early strobes of a dwell group or strobes in the idle phase, are followed by a check at that same falling edge, before the next stimulus.

// File: rtl/fwt_pkg.sv
package fwt_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SEARCH = 2'd1,
        PH_TRACK  = 2'd2
    } phase_e;

endpackage

// File: rtl/fwt_search_unit.sv
module fwt_search_unit #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] fsw,
    input  logic [WORD_W-1:0] step,
    input  logic              dir_up,
    output logic [WORD_W-1:0] fsw_nxt,
    output logic [WORD_W-1:0] step_nxt,
    output logic              final_step
);
    // One binary-search approximation: add or remove the step, halve it.
    always_comb begin
        fsw_nxt    = dir_up ? (fsw + step) : (fsw - step);
        step_nxt   = step >> 1;
        final_step = (step == WORD_W'(1));
    end
endmodule

// File: rtl/fwt_track_unit.sv
module fwt_track_unit #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] fsw,
    input  logic              dir_up,
    output logic [WORD_W-1:0] fsw_nxt
);
    localparam logic [WORD_W-1:0] TOP = '1;

    // Unit step with saturation at both ends of the range.
    always_comb begin
        fsw_nxt = fsw;
        if (dir_up) begin
            if (fsw != TOP) fsw_nxt = fsw + WORD_W'(1);
        end else begin
            if (fsw != '0)  fsw_nxt = fsw - WORD_W'(1);
        end
    end
endmodule

// File: rtl/fwt_extremes.sv
module fwt_extremes #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              evt,
    input  logic              dir_up,
    input  logic [WORD_W-1:0] fsw,
    output logic [WORD_W-1:0] ext_lo,
    output logic [WORD_W-1:0] ext_hi,
    output logic [WORD_W-1:0] reading,
    output logic              valid
);
    typedef struct packed {
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
        logic              got_lo;
        logic              got_hi;
        logic              seen;
        logic              prev_up;
    } ext_t;

    ext_t    s_d, s_q;
    logic [WORD_W:0] sum;

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d.got_lo = 1'b0;
            s_d.got_hi = 1'b0;
            s_d.seen   = 1'b0;
        end else if (evt) begin
            if (s_q.seen && !s_q.prev_up && dir_up) begin
                s_d.lo     = fsw;
                s_d.got_lo = 1'b1;
            end
            if (s_q.seen && s_q.prev_up && !dir_up) begin
                s_d.hi     = fsw;
                s_d.got_hi = 1'b1;
            end
            s_d.seen    = 1'b1;
            s_d.prev_up = dir_up;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        sum     = {1'b0, s_q.lo} + {1'b0, s_q.hi};
        reading = sum[WORD_W:1];
        ext_lo  = s_q.lo;
        ext_hi  = s_q.hi;
        valid   = s_q.got_lo & s_q.got_hi;
    end
endmodule

// File: rtl/freq_word_tracker.sv
module freq_word_tracker #(
    parameter int WORD_W  = 16,
    parameter int DWELL_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               strobe,
    input  logic               dir_up,
    input  logic [DWELL_W-1:0] dwell,
    output logic [WORD_W-1:0]  fsw,
    output logic [1:0]         phase,
    output logic [WORD_W-1:0]  ext_lo,
    output logic [WORD_W-1:0]  ext_hi,
    output logic [WORD_W-1:0]  reading,
    output logic               reading_valid
);
    import fwt_pkg::*;

    localparam logic [WORD_W-1:0] MID_WORD   = {1'b1, {(WORD_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] FIRST_STEP = {2'b01, {(WORD_W-2){1'b0}}};

    typedef struct packed {
        phase_e             phase;
        logic [WORD_W-1:0]  fsw;
        logic [WORD_W-1:0]  step;
        logic [DWELL_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    logic [WORD_W-1:0]  srch_fsw, srch_step, trk_fsw;
    logic               srch_final;
    logic [DWELL_W-1:0] cnt_last;
    logic               group_done;
    logic               trk_evt;

    fwt_search_unit #(.WORD_W(WORD_W)) i_search (
        .fsw        (st_q.fsw),
        .step       (st_q.step),
        .dir_up     (dir_up),
        .fsw_nxt    (srch_fsw),
        .step_nxt   (srch_step),
        .final_step (srch_final)
    );

    fwt_track_unit #(.WORD_W(WORD_W)) i_track (
        .fsw     (st_q.fsw),
        .dir_up  (dir_up),
        .fsw_nxt (trk_fsw)
    );

    always_comb begin
        cnt_last   = (dwell == '0) ? '0 : (dwell - DWELL_W'(1));
        group_done = (st_q.cnt >= cnt_last);
        trk_evt    = strobe && !start && (st_q.phase == PH_TRACK);

        st_d = st_q;
        if (start) begin
            st_d.phase = PH_SEARCH;
            st_d.fsw   = MID_WORD;
            st_d.step  = FIRST_STEP;
            st_d.cnt   = '0;
        end else if (strobe) begin
            unique case (st_q.phase)
                PH_SEARCH: begin
                    if (group_done) begin
                        st_d.fsw = srch_fsw;
                        st_d.cnt = '0;
                        if (srch_final) st_d.phase = PH_TRACK;
                        else            st_d.step  = srch_step;
                    end else begin
                        st_d.cnt = st_q.cnt + DWELL_W'(1);
                    end
                end
                PH_TRACK: st_d.fsw = trk_fsw;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.fsw   <= '0;
            st_q.step  <= '0;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    fwt_extremes #(.WORD_W(WORD_W)) i_extremes (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .evt     (trk_evt),
        .dir_up  (dir_up),
        .fsw     (st_q.fsw),
        .ext_lo  (ext_lo),
        .ext_hi  (ext_hi),
        .reading (reading),
        .valid   (reading_valid)
    );

    assign fsw   = st_q.fsw;
    assign phase = st_q.phase;

endmodule

// File: rtl/fwt_checker.sv
module fwt_checker #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              strobe,
    input logic              dir_up,
    input logic [WORD_W-1:0] fsw,
    input logic [1:0]        phase,
    input logic              reading_valid
);
    localparam logic [WORD_W-1:0] MID_WORD = {1'b1, {(WORD_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] TOP      = '1;

    assert_start_mid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (fsw == MID_WORD && phase == 2'd1));

    assert_search_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1) |-> (fsw != '0));

    assert_track_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && !start) |=> (phase == 2'd2));

    assert_track_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && strobe && !start && dir_up && fsw != TOP)
        |=> (fsw == $past(fsw) + WORD_W'(1)));

    assert_track_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && strobe && !start && !dir_up && fsw == '0) |=> (fsw == '0));

    assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !reading_valid);

    assert_hold_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !strobe) |=> ($stable(fsw) && $stable(phase)));
endmodule

bind freq_word_tracker fwt_checker #(.WORD_W(WORD_W)) i_fwt_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .strobe        (strobe),
    .dir_up        (dir_up),
    .fsw           (fsw),
    .phase         (phase),
    .reading_valid (reading_valid)
);

// File: tb/test_freq_word_tracker.sv
`timescale 1ns/1ps
module test_freq_word_tracker;
    localparam int W  = 16;
    localparam int DW = 4;
    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] QTR = {2'b01, {(W-2){1'b0}}};
    localparam logic [W-1:0] TOP = '1;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, strobe = 1'b0, dir_up = 1'b0;
    logic [DW-1:0] dwell = 4'd1;
    logic [W-1:0]  fsw, ext_lo, ext_hi, reading;
    logic [1:0]    phase;
    logic          reading_valid;

    int n_tests = 0, n_fail = 0;

    // Reference model state
    logic [W-1:0] m_fsw, m_lo, m_hi;
    logic m_got_lo, m_got_hi, m_seen, m_prev_up;

    always #2.5 clk = ~clk;

    freq_word_tracker #(.WORD_W(W), .DWELL_W(DW)) i_freq_word_tracker (
        .clk(clk), .rst_n(rst_n), .start(start), .strobe(strobe), .dir_up(dir_up),
        .dwell(dwell), .fsw(fsw), .phase(phase), .ext_lo(ext_lo), .ext_hi(ext_hi),
        .reading(reading), .reading_valid(reading_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_strobe(input logic d);
        @(negedge clk); strobe = 1'b1; dir_up = d;
        @(negedge clk); strobe = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        m_got_lo = 1'b0; m_got_hi = 1'b0; m_seen = 1'b0;
    endtask

    // Start, then run a full search toward target with the given dwell.
    task automatic t_search(input logic [W-1:0] target, input logic [DW-1:0] dw);
        logic [W-1:0] step;
        int eff;
        dwell = dw;
        eff = (dw == 0) ? 1 : int'(dw);
        pulse_start();
        chk("R2 word after start", fsw, MID);
        chk("R2 phase after start", phase, 1);
        chk("R10 valid after start", reading_valid, 0);
        m_fsw = MID;
        step  = QTR;
        for (int i = 0; i < W-1; i++) begin
            logic up;
            up = (m_fsw < target);
            for (int k = 0; k < eff-1; k++) begin
                pulse_strobe(!up);
                chk("R4 early strobe no effect", fsw, m_fsw);
            end
            pulse_strobe(up);
            m_fsw = up ? m_fsw + step : m_fsw - step;
            chk("R3 approximation word", fsw, m_fsw);
            chk("R5 phase after approximation", phase, (step == 1) ? 2 : 1);
            step = step >> 1;
        end
    endtask

    // One track strobe with full model update and checks.
    task automatic t_track_step(input logic up);
        if (m_seen && !m_prev_up && up) begin m_lo = m_fsw; m_got_lo = 1'b1; end
        if (m_seen && m_prev_up && !up) begin m_hi = m_fsw; m_got_hi = 1'b1; end
        m_seen = 1'b1; m_prev_up = up;
        if (up && m_fsw != TOP) m_fsw = m_fsw + 1'b1;
        else if (!up && m_fsw != 0) m_fsw = m_fsw - 1'b1;
        pulse_strobe(up);
        chk("R6 R7 track word", fsw, m_fsw);
        chk("R8 lower extreme", ext_lo, m_lo);
        chk("R8 upper extreme", ext_hi, m_hi);
        chk("R9 valid flag", reading_valid, m_got_lo & m_got_hi);
        chk("R9 reading", reading, W'(({1'b0, m_lo} + {1'b0, m_hi}) >> 1));
    endtask

    task automatic t_follow(input logic [W-1:0] target, input int n);
        for (int i = 0; i < n; i++) t_track_step(m_fsw < target);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_fsw = '0; m_lo = '0; m_hi = '0;
        m_got_lo = 1'b0; m_got_hi = 1'b0; m_seen = 1'b0; m_prev_up = 1'b0;
        chk("R1 reset word", fsw, 0);
        chk("R1 reset phase", phase, 0);
        chk("R1 reset lower", ext_lo, 0);
        chk("R1 reset upper", ext_hi, 0);
        chk("R1 reset valid", reading_valid, 0);
    endtask

    task automatic t_idle_ignore();
        pulse_strobe(1'b1);
        chk("R11 idle strobe word", fsw, 0);
        chk("R11 idle strobe phase", phase, 0);
    endtask

    task automatic t_quiet_hold();
        repeat (5) @(negedge clk);
        chk("R11 hold word", fsw, m_fsw);
        chk("R11 hold phase", phase, 2);
    endtask

    task automatic t_start_priority();
        @(negedge clk); start = 1'b1; strobe = 1'b1; dir_up = 1'b1;
        @(negedge clk); start = 1'b0; strobe = 1'b0;
        m_got_lo = 1'b0; m_got_hi = 1'b0; m_seen = 1'b0;
        chk("R2 start beats strobe word", fsw, MID);
        chk("R10 restart phase", phase, 1);
        chk("R10 restart valid", reading_valid, 0);
    endtask

    task automatic t_saturate_top();
        t_search(TOP, 4'd1);
        chk("R3 search reaches top", fsw, TOP);
        t_track_step(1'b1);
        t_track_step(1'b1);
    endtask

    task automatic t_saturate_bottom();
        t_search('0, 4'd1);
        chk("R3 search floor is one", fsw, 1);
        t_track_step(1'b0);
        t_track_step(1'b0);
        t_track_step(1'b0);
    endtask

    initial begin
        t_reset();
        t_idle_ignore();
        t_search(16'd1000, 4'd1);
        t_follow(16'd1000, 10);
        t_quiet_hold();
        t_follow(16'd1003, 10);
        t_start_priority();
        t_search(16'd40000, 4'd3);
        t_follow(16'd40000, 6);
        t_search(16'd12345, 4'd0);
        t_follow(16'd12345, 6);
        t_saturate_top();
        t_saturate_bottom();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule